// File: doc/BRIEF.md
# Programmable Colour Correction Matrix

This pixel-pipeline stage multiplies every RGB pixel by a programmable 3x3 matrix of signed gains. Pixels arrive and leave on valid/ready streams at up to one pixel per clock, with one register stage between input and output. A small register bus holds a run bit, a configuration word, the frame dimensions and nine coefficients. Coefficients are written into a staging copy and only reach the multipliers when a new frame begins, so a matrix update never splits a frame.

Each output channel is the sum of three products of the 10-bit input channels with 12-bit sign-magnitude gains. The sum is rounded, floored at zero, and then either saturated at full scale or wrapped modulo 1024, depending on a clip bit. A relay setting, or a cleared engine bit, passes pixels through unchanged with the same latency.

Top module: `color_matrix`

## Requirements
- R1: After reset the block is stopped (in_ready_o and out_valid_o low), the enable, configuration and size registers read 0, and the coefficient registers read an identity matrix (0x80, 0x88 and 0x90 read 0x04000000; 0x84 and 0x8C read 0).
- R2: Register map. 0x00 bit 0 is the run bit. 0x20 has bit 0 relay, bit 1 engine enable, bit 2 gamma-off (stored only) and bit 3 clip. 0x30 has height in bits 31:16 and width in 15:0. 0x80, 0x84, 0x88, 0x8C and 0x90 hold coefficients c0..c8 in row-major order, with the even-indexed one in bits 27:16 and the odd-indexed one in bits 11:0; 0x90 holds only c8. Reads return the last written staged value, with undefined bits reading 0.
- R3: in_ready_o equals run and (output empty or out_ready_i). An accepted pixel appears on out_valid_o in the next cycle, and a stalled output holds its data.
- R4: While the run bit is 0, in_ready_o and out_valid_o are low and input pixels are not taken.
- R5: When relay is set or engine enable is clear, the output pixel equals the accepted input pixel.
- R6: Pixels carry R in bits 29:20, G in 19:10 and B in 9:0. Output channel r equals c(3r)*R + c(3r+1)*G + c(3r+2)*B. Coefficient bit 11 is the sign and bits 10:0 the magnitude, with 0x400 = 1.0.
- R7: The sum is rounded by adding 512 and shifting right arithmetically by 10. A negative result gives 0.
- R8: With clip set, results above 1023 give 1023. With clip clear, they keep the low 10 bits.
- R9: Coefficient writes take effect at the first pixel of the next frame. A frame is width*height accepted pixels. The pixel count is held at 0 while stopped. With width*height of 0 or 1, every pixel after the current one starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted when high with valid |
| in_data_i | input | 30 | Input pixel, R/G/B 10 bits each |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 30 | Output pixel, R/G/B 10 bits each |

## Verification
The bench targets a coefficient write landing in the middle of a frame. A design that loaded the write at once would change the gain for the pixels that remain in that frame. It also covers zero frame size, where a counter that never wraps would hold the old matrix for good. Full-scale gains on full-scale pixels show whether clip-off wraps or saturates, and a negative row shows whether negative sums are floored rather than left to wrap. Random backpressure catches outputs that change while stalled or pixels that are lost. Rounding at the half-LSB point catches truncation.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  localparam int unsigned NCH   = 3;
  localparam int unsigned NCOEF = NCH * NCH;

  localparam logic [7:0] OFS_RUN   = 8'h00;
  localparam logic [7:0] OFS_CFG   = 8'h20;
  localparam logic [7:0] OFS_SIZE  = 8'h30;
  localparam logic [7:0] OFS_COEF0 = 8'h80;

  // field order matches register bit positions 3..0
  typedef struct packed {
    logic clip;
    logic gamma_off;
    logic engine;
    logic relay;
  } cfg_t;
endpackage

// File: rtl/ccm_regs.sv
module ccm_regs
  import ccm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned COEF_W = 12,
  parameter int unsigned FRAC_W = 10,
  parameter int unsigned DIM_W  = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [31:0]                   wdata_i,
  output logic [31:0]                   rdata_o,
  input  logic                          frame_start_i,
  output logic                          run_o,
  output cfg_t                          cfg_o,
  output logic [DIM_W-1:0]              width_o,
  output logic [DIM_W-1:0]              height_o,
  output logic [NCOEF-1:0][COEF_W-1:0]  staged_o,
  output logic [NCOEF-1:0][COEF_W-1:0]  active_o
);
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC_W;

  function automatic logic [ADDR_W-1:0] coef_addr(input int unsigned k);
    return ADDR_W'(OFS_COEF0) + ADDR_W'(4 * (k / 2));
  endfunction

  function automatic logic [COEF_W-1:0] ident(input int unsigned k);
    return (k % (NCH + 1) == 0) ? UNITY : '0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o    <= 1'b0;
      cfg_o    <= '0;
      width_o  <= '0;
      height_o <= '0;
      for (int unsigned k = 0; k < NCOEF; k++) begin
        staged_o[k] <= ident(k);
        active_o[k] <= ident(k);
      end
    end else begin
      if (we_i) begin
        if (addr_i == ADDR_W'(OFS_RUN))  run_o <= wdata_i[0];
        if (addr_i == ADDR_W'(OFS_CFG))  cfg_o <= cfg_t'(wdata_i[3:0]);
        if (addr_i == ADDR_W'(OFS_SIZE)) begin
          height_o <= wdata_i[16 +: DIM_W];
          width_o  <= wdata_i[0 +: DIM_W];
        end
        for (int unsigned k = 0; k < NCOEF; k++) begin
          if (addr_i == coef_addr(k)) begin
            if (k % 2 == 0) staged_o[k] <= wdata_i[16 +: COEF_W];
            else            staged_o[k] <= wdata_i[0 +: COEF_W];
          end
        end
      end
      if (frame_start_i) active_o <= staged_o;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_RUN)) rdata_o[0] = run_o;
    if (addr_i == ADDR_W'(OFS_CFG)) rdata_o[3:0] = cfg_o;
    if (addr_i == ADDR_W'(OFS_SIZE)) begin
      rdata_o[16 +: DIM_W] = height_o;
      rdata_o[0 +: DIM_W]  = width_o;
    end
    for (int unsigned k = 0; k < NCOEF; k++) begin
      if (addr_i == coef_addr(k)) begin
        if (k % 2 == 0) rdata_o[16 +: COEF_W] = staged_o[k];
        else            rdata_o[0 +: COEF_W]  = staged_o[k];
      end
    end
  end
endmodule

// File: rtl/ccm_frame_ctr.sv
module ccm_frame_ctr #(
  parameter int unsigned DIM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             accept_i,
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  output logic             first_o
);
  localparam int unsigned CNT_W = 2 * DIM_W + 1;

  logic [CNT_W-1:0] cnt_q, total, cnt_inc;

  assign total   = CNT_W'(width_i) * CNT_W'(height_i);
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign first_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (accept_i) cnt_q <= (cnt_inc >= total) ? '0 : cnt_inc;
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> first_o) else $error("count not cleared while stopped"); // R9
endmodule

// File: rtl/ccm_mac.sv
module ccm_mac
  import ccm_pkg::*;
#(
  parameter int unsigned PIX_W  = 10,
  parameter int unsigned COEF_W = 12,
  parameter int unsigned FRAC_W = 10
) (
  input  logic [NCH*PIX_W-1:0]         pix_i,
  input  logic [NCOEF-1:0][COEF_W-1:0] coef_i,
  input  logic                         bypass_i,
  input  logic                         clip_i,
  output logic [NCH*PIX_W-1:0]         res_o
);
  localparam int unsigned ACC_W = PIX_W + COEF_W + 2;
  localparam logic signed [ACC_W-1:0] RND_HALF = ACC_W'(2 ** (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] MAXV     = ACC_W'((2 ** PIX_W) - 1);

  for (genvar r = 0; r < NCH; r++) begin : g_row
    logic signed [ACC_W-1:0] acc, rnd;
    logic        [PIX_W-1:0] ch;

    always_comb begin
      logic [ACC_W-1:0] mag, px, prod;
      acc = '0;
      for (int unsigned j = 0; j < NCH; j++) begin
        mag  = ACC_W'(coef_i[r*NCH+j][COEF_W-2:0]);
        px   = ACC_W'(pix_i[(NCH-1-j)*PIX_W +: PIX_W]);
        prod = mag * px;
        if (coef_i[r*NCH+j][COEF_W-1]) acc = acc - $signed(prod);
        else                           acc = acc + $signed(prod);
      end
      rnd = (acc + RND_HALF) >>> FRAC_W;
      if (bypass_i)                  ch = pix_i[(NCH-1-r)*PIX_W +: PIX_W];
      else if (rnd[ACC_W-1])         ch = '0;
      else if (clip_i && rnd > MAXV) ch = MAXV[PIX_W-1:0];
      else                           ch = rnd[PIX_W-1:0];
    end

    assign res_o[(NCH-1-r)*PIX_W +: PIX_W] = ch;
  end
endmodule

// File: rtl/color_matrix.sv
module color_matrix
  import ccm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PIX_W  = 10,
  parameter int unsigned COEF_W = 12,
  parameter int unsigned FRAC_W = 10,
  parameter int unsigned DIM_W  = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [NCH*PIX_W-1:0] in_data_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [NCH*PIX_W-1:0] out_data_o
);
  localparam int unsigned DATA_W = NCH * PIX_W;

  logic                        run, first, accept, bypass, vld_q;
  cfg_t                        cfg;
  logic [DIM_W-1:0]            width, height;
  logic [NCOEF-1:0][COEF_W-1:0] staged, active, coef_sel;
  logic [DATA_W-1:0]           res, dat_q;

  assign in_ready_o  = run && (!vld_q || out_ready_i);
  assign accept      = in_valid_i && in_ready_o;
  assign out_valid_o = vld_q && run;
  assign out_data_o  = dat_q;
  assign bypass      = cfg.relay || !cfg.engine;
  // first pixel of a frame already uses the staged set
  assign coef_sel    = first ? staged : active;

  ccm_regs #(
    .ADDR_W(ADDR_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .DIM_W(DIM_W)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .frame_start_i(accept && first),
    .run_o        (run),
    .cfg_o        (cfg),
    .width_o      (width),
    .height_o     (height),
    .staged_o     (staged),
    .active_o     (active)
  );

  ccm_frame_ctr #(.DIM_W(DIM_W)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .accept_i(accept),
    .width_i (width),
    .height_i(height),
    .first_o (first)
  );

  ccm_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_mac (
    .pix_i   (in_data_i),
    .coef_i  (coef_sel),
    .bypass_i(bypass),
    .clip_i  (cfg.clip),
    .res_o   (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      if (!run)            vld_q <= 1'b0;
      else if (in_ready_o) vld_q <= in_valid_i;
      if (accept) dat_q <= res;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> $stable(out_data_o)) else $error("stalled data moved"); // R3
  AST_ACCEPT_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o || !run) else $error("accepted pixel lost"); // R3
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !in_ready_o && !out_valid_o) else $error("active while stopped"); // R4
  AST_BYPASS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && bypass |=> out_data_o == $past(in_data_i)) else $error("bypass altered pixel"); // R5
endmodule

// File: tb/tb_color_matrix.sv
module tb_color_matrix;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [29:0] in_data = '0, out_data;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  color_matrix dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .in_data_i(in_data), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data)
  );

  // ---------------- reference model ----------------
  bit               m_run, m_vld;
  logic [3:0]       m_cfg;
  int unsigned      m_w, m_h, m_cnt;
  logic [8:0][11:0] m_stg, m_act;
  logic [29:0]      m_dat;

  function automatic int sm(input logic [11:0] c);
    return c[11] ? -int'(c[10:0]) : int'(c[10:0]);
  endfunction

  function automatic logic [29:0] ref_pix(input logic [29:0] d, input logic [8:0][11:0] c,
                                          input bit byp, input bit clp);
    logic [29:0] o;
    int ch[3];
    if (byp) return d;
    for (int j = 0; j < 3; j++) ch[j] = int'(d[(2-j)*10 +: 10]);
    for (int r = 0; r < 3; r++) begin
      int acc, v;
      acc = 0;
      for (int j = 0; j < 3; j++) acc += sm(c[r*3+j]) * ch[j];
      v = (acc + 512) >>> 10;
      if (v < 0) v = 0;
      else if (clp && v > 1023) v = 1023;
      else v = v & 1023;
      o[(2-r)*10 +: 10] = 10'(v);
    end
    return o;
  endfunction

  function automatic logic [8:0][11:0] ident();
    logic [8:0][11:0] c = '0;
    c[0] = 12'h400; c[4] = 12'h400; c[8] = 12'h400;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_vld <= 0; m_cfg <= '0; m_w <= 0; m_h <= 0; m_cnt <= 0;
      m_stg <= ident(); m_act <= ident(); m_dat <= '0;
    end else begin
      automatic bit rdy = m_run && (!m_vld || out_ready);
      automatic bit acc = in_valid && rdy;
      if (acc) begin
        m_dat <= ref_pix(in_data, (m_cnt == 0) ? m_stg : m_act, m_cfg[0] || !m_cfg[1], m_cfg[3]);
        if (m_cnt == 0) m_act <= m_stg;
      end
      if (!m_run) m_vld <= 0; else if (rdy) m_vld <= in_valid;
      if (!m_run) m_cnt <= 0;
      else if (acc) m_cnt <= (longint'(m_cnt) + 1 >= longint'(m_w) * longint'(m_h)) ? 0 : m_cnt + 1;
      if (we) begin
        if (addr == 8'h00) m_run <= wdata[0];
        if (addr == 8'h20) m_cfg <= wdata[3:0];
        if (addr == 8'h30) begin m_h <= wdata[31:16]; m_w <= wdata[15:0]; end
        if (addr >= 8'h80 && addr <= 8'h90 && addr[1:0] == 2'b00) begin
          automatic int i = (int'(addr) - 'h80) / 4;
          m_stg[2*i] <= wdata[27:16];
          if (2*i+1 < 9) m_stg[2*i+1] <= wdata[11:0];
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit e_rdy = m_run && (!m_vld || out_ready);
      automatic bit e_vld = m_vld && m_run;
      compared++;
      if (in_ready !== e_rdy || out_valid !== e_vld || (e_vld && out_data !== m_dat)) begin
        mismatched++;
        $display("FAIL %s cycle: rdy=%0b vld=%0b data=%h expected rdy=%0b vld=%0b data=%h",
                 cur_req, in_ready, out_valid, out_data, e_rdy, e_vld, m_dat);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2; we = 1; addr = a; wdata = d;
    @(posedge clk); #2; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #2; addr = a; #1; d = rdata;
  endtask

  task automatic wr_mat(input logic [8:0][11:0] c);
    wr(8'h80, {4'h0, c[0], 4'h0, c[1]});
    wr(8'h84, {4'h0, c[2], 4'h0, c[3]});
    wr(8'h88, {4'h0, c[4], 4'h0, c[5]});
    wr(8'h8C, {4'h0, c[6], 4'h0, c[7]});
    wr(8'h90, {4'h0, c[8], 16'h0});
  endtask

  task automatic stream(input int n, input int vpct, input int rpct);
    int sent = 0;
    bit taken = 0;
    forever begin
      @(posedge clk); #2;
      if (taken) sent++;
      if (sent >= n) break;
      if (!in_valid || taken) begin
        in_valid = ($urandom % 100) < vpct;
        in_data  = 30'($urandom);
      end
      out_ready = ($urandom % 100) < rpct;
      @(negedge clk);
      taken = in_valid && in_ready;
    end
    in_valid = 0; out_ready = 1;
    repeat (3) @(posedge clk);
  endtask

  task automatic px1(input logic [29:0] d, output logic [29:0] o);
    @(posedge clk); #2; in_valid = 1; in_data = d; out_ready = 1;
    @(posedge clk); #2; in_valid = 0;
    @(negedge clk); o = out_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [29:0] o;
    logic [8:0][11:0] c;

    repeat (3) @(posedge clk); #2; rst_n = 1;

    // R1 reset state
    @(negedge clk);
    chk("R1 ready", {31'd0, in_ready}, 0);
    chk("R1 valid", {31'd0, out_valid}, 0);
    rd(8'h00, r); chk("R1 run reg", r, 0);
    rd(8'h20, r); chk("R1 cfg reg", r, 0);
    rd(8'h30, r); chk("R1 size reg", r, 0);
    rd(8'h80, r); chk("R1 coef 0x80", r, 32'h0400_0000);
    rd(8'h84, r); chk("R1 coef 0x84", r, 0);
    rd(8'h88, r); chk("R1 coef 0x88", r, 32'h0400_0000);
    rd(8'h8C, r); chk("R1 coef 0x8C", r, 0);
    rd(8'h90, r); chk("R1 coef 0x90", r, 32'h0400_0000);

    // R4 stopped: offered pixels not taken
    cur_req = "R4";
    @(posedge clk); #2; in_valid = 1; in_data = 30'h1234567;
    repeat (4) @(negedge clk);
    chk("R4 ready while stopped", {31'd0, in_ready}, 0);
    chk("R4 valid while stopped", {31'd0, out_valid}, 0);
    @(posedge clk); #2; in_valid = 0;

    // R2 register map and unused bits
    cur_req = "R2";
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, r); chk("R2 cfg bits", r, 32'h0000_000F);
    wr(8'h30, 32'h0002_0003); rd(8'h30, r); chk("R2 size h/w", r, 32'h0002_0003);
    wr(8'h84, 32'hFFFF_FFFF); rd(8'h84, r); chk("R2 coef pair", r, 32'h0FFF_0FFF);
    wr(8'h90, 32'hFFFF_FFFF); rd(8'h90, r); chk("R2 coef last", r, 32'h0FFF_0000);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, r); chk("R2 run bit", r, 32'h1);
    wr(8'h00, 0);

    // R3/R6 identity matrix with backpressure
    cur_req = "R3/R6";
    wr_mat(ident()); wr(8'h30, 32'h0002_0002); wr(8'h20, 32'h2); wr(8'h00, 1);
    stream(30, 70, 60);

    // R9 shadow timing, frame of 2x2
    cur_req = "R9";
    wr(8'h00, 0); wr(8'h00, 1);
    px1({10'd400, 20'd0}, o); chk("R9 first pixel identity", {2'b0, o}, {2'b0, 10'd400, 20'd0});
    wr(8'h80, 32'h0200_0000);
    px1({10'd400, 20'd0}, o); chk("R9 mid-frame keeps old gain", {2'b0, o}, {2'b0, 10'd400, 20'd0});
    px1({10'd400, 20'd0}, o);
    px1({10'd400, 20'd0}, o); chk("R9 last pixel of frame", {2'b0, o}, {2'b0, 10'd400, 20'd0});
    px1({10'd400, 20'd0}, o); chk("R9 new frame uses new gain", {2'b0, o}, {2'b0, 10'd200, 20'd0});
    wr(8'h30, 0); wr(8'h80, 32'h0400_0000);
    px1({10'd400, 20'd0}, o); chk("R9 zero size finishes current", {2'b0, o}, {2'b0, 10'd200, 20'd0});
    px1({10'd400, 20'd0}, o); chk("R9 zero size next frame", {2'b0, o}, {2'b0, 10'd400, 20'd0});
    wr(8'h80, 32'h0200_0000);
    px1({10'd400, 20'd0}, o); chk("R9 zero size immediate", {2'b0, o}, {2'b0, 10'd200, 20'd0});

    // R7 rounding at half LSB
    cur_req = "R7";
    c = ident(); c[0] = 12'h001; wr_mat(c);
    px1({10'd0, 20'd0}, o);
    px1({10'd512, 20'd0}, o); chk("R7 half rounds up", {22'd0, o[29:20]}, 1);
    px1({10'd511, 20'd0}, o); chk("R7 below half rounds down", {22'd0, o[29:20]}, 0);

    // R8 / R7 saturation, wrap and negative floor
    cur_req = "R8";
    c = '0; c[0] = 12'h7FF; c[1] = 12'h7FF; c[2] = 12'h7FF; c[3] = 12'hC00; c[8] = 12'h400;
    wr_mat(c); wr(8'h20, 32'hA);
    px1('1, o);
    px1('1, o);
    chk("R8 clip saturates", {22'd0, o[29:20]}, 1023);
    chk("R7 negative floors (clip)", {22'd0, o[19:10]}, 0);
    chk("R6 unity channel", {22'd0, o[9:0]}, 1023);
    wr(8'h20, 32'h2);
    px1('1, o);
    chk("R8 no clip wraps", {22'd0, o[29:20]}, 1015);
    chk("R7 negative floors (no clip)", {22'd0, o[19:10]}, 0);

    // R6/R7/R8 random matrices, both clip settings
    cur_req = "R6/R7/R8";
    wr(8'h30, 32'h0003_0002);
    for (int t = 0; t < 4; t++) begin
      for (int k = 0; k < 9; k++) c[k] = 12'($urandom);
      wr_mat(c);
      wr(8'h20, (t % 2) ? 32'hA : 32'h2);
      stream(25, 80, 75);
    end

    // R5 bypass by relay and by engine off
    cur_req = "R5";
    wr(8'h20, 32'h3);
    px1(30'h2AB_CDEF, o); px1(30'h1357_9BD, o); chk("R5 relay passes", {2'b0, o}, {2'b0, 30'h1357_9BD});
    stream(20, 90, 50);
    wr(8'h20, 32'h8);
    px1(30'h3FF_0001, o); px1(30'h0F0_F0F0, o); chk("R5 engine off passes", {2'b0, o}, {2'b0, 30'h0F0_F0F0});

    // R4 stop with a pending output and input offered
    cur_req = "R4";
    @(posedge clk); #2; in_valid = 1; in_data = 30'h155; out_ready = 0;
    @(posedge clk); #2;
    wr(8'h00, 0);
    @(negedge clk);
    chk("R4 ready after stop", {31'd0, in_ready}, 0);
    chk("R4 valid after stop", {31'd0, out_valid}, 0);
    @(posedge clk); #2; in_valid = 0; out_ready = 1;
    repeat (3) @(posedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule